// File: doc/BRIEF.md
# Outphasing RF Pulse-Width Modulator

This block turns a stream of polar envelope samples into a single binary drive pulse per carrier period, for a switching power amplifier. A carrier period is a fixed, power-of-two number of fast-clock ticks. The amplitude is mapped through an arc-cosine table to an outphasing angle in ticks. Two square waves, each high for half a period, are placed that angle ahead of and behind the programmed phase. Their logical AND is the drive pulse. The pulse width therefore follows the amplitude, and the pulse centre follows the phase.

A sample strobe captures amplitude, phase, a minimum pulse width, an under-width policy and four slice enables. The captured values are applied only at the next carrier boundary, so a period is never split between two samples. Pulses narrower than the programmed minimum would be swallowed by the output driver. Depending on the policy bit, such a pulse is either widened to the minimum or left out for that period. The slice enables, which switch parallel output paths on or off, are registered and change only at the same boundary. A marker output flags the first tick of every period.

Top module: `rfpwm_outphase`

## Requirements
- R1: While the active amplitude is non-zero and the resulting width lies between 1 and N-1 ticks, each period holds exactly one contiguous high run, counted circularly over the N ticks of the period.
- R2: `period_start_o` is high for one cycle every N cycles (N = `PERIOD` = 64). `pulse_o` and `slice_en_o` in that cycle show tick 0 of the period.
- R3: The outphasing angle is theta = round(acos(A/(2^AMP_W-1)) * N/(2*pi)) ticks, where A is the unsigned amplitude code (255 means 1.0). The high time is N/2 - 2*theta, which is within one tick of round(N*(0.5 - acos(A/255)/pi)). Full scale gives exactly N/2 ticks (50 % duty), and no period holds more than N/2 high ticks.
- R4: The pulse begins at tick (P + (N/2 - W)/2) mod N, where P is the phase code (one tick per LSB) and W is the high time. The pulse centre therefore sits a fixed quarter period after the programmed phase.
- R5: With `raise_mode_i` = 1, a width below `min_width_i` is raised to `min_width_i` or `min_width_i`+1, capped at N/2. The centre stays as in R4.
- R6: With `raise_mode_i` = 0, a period whose width would be below `min_width_i` carries no pulse at all.
- R7: An amplitude code of 0 keeps `pulse_o` low for the whole period, whatever the policy bit.
- R8: A sample taken while the counter is at tick c < N-1 applies from the next period start. A sample taken at c = N-1 applies one period later. The period in progress keeps its values.
- R9: `slice_en_o` (bit i enables output path i) is registered and changes only in a cycle where `period_start_o` is high.
- R10: While `rst_n` is low, `pulse_o`, `period_start_o` and `slice_en_o` are 0. After release, the first period begins in the first cycle and the amplitude, and with it the pulse, is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| samp_valid_i | input | 1 | Strobe that captures the sample inputs |
| samp_amp_i | input | 8 | Envelope amplitude, unsigned, 255 = 1.0 |
| samp_phase_i | input | 6 | Carrier phase in ticks |
| min_width_i | input | 6 | Minimum pulse width in ticks |
| raise_mode_i | input | 1 | Under-width policy: 1 widen, 0 drop |
| slice_req_i | input | 4 | Requested output-path enables |
| pulse_o | output | 1 | Registered drive pulse |
| period_start_o | output | 1 | High during tick 0 of each period |
| slice_en_o | output | 4 | Registered output-path enables |

## Verification
`pulse_o` for counter tick c appears one cycle after the counter holds c. `period_start_o` and `slice_en_o` go through the same register stage, so all three outputs line up on tick 0 of a period. A strobed sample is due in the first period that starts after the strobe's capture edge. The bench times every strobe from the start marker, driving it in the third cycle of a period. It then queues two expectations: the old values for the period in progress and the new values for the next one. The monitor rebuilds each period tick by tick from the marker. At the following marker it compares width, circular start position, run count and slice enables against the expectation queued for that period.

// File: rtl/rfpwm_pkg.sv
`timescale 1ns/1ps
package rfpwm_pkg;

  localparam real PI_R = 3.14159265358979;

  // Under-width handling policy
  typedef enum logic {
    UNDER_DROP  = 1'b0,
    UNDER_RAISE = 1'b1
  } under_mode_e;

  // Outphasing angle in ticks for one amplitude code, clipped to a quarter period
  function automatic int acos_ticks(int code, int code_max, int period);
    real ratio;
    real ang;
    real ticks;
    int  t;
    ratio = real'(code) / real'(code_max);
    if (ratio > 1.0) ratio = 1.0;
    if (ratio < 0.0) ratio = 0.0;
    ang   = $acos(ratio);
    ticks = ang * real'(period) / (2.0 * PI_R);
    t     = $rtoi(ticks + 0.5);
    if (t > period / 4) t = period / 4;
    return t;
  endfunction

endpackage

// File: rtl/rfpwm_tick_ctr.sv
`timescale 1ns/1ps
module rfpwm_tick_ctr #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned TW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] cnt_o,
  output logic          last_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == TW'(PERIOD - 1));
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = at_last;

endmodule

// File: rtl/rfpwm_acos_lut.sv
`timescale 1ns/1ps
module rfpwm_acos_lut #(
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned PERIOD = 64,
  parameter int unsigned TW     = $clog2(PERIOD)
) (
  input  logic [AMP_W-1:0] amp_i,
  output logic [TW-1:0]    theta_o
);

  localparam int unsigned DEPTH   = 1 << AMP_W;
  localparam int unsigned AMP_MAX = DEPTH - 1;

  logic [TW-1:0] rom [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_rom
    assign rom[g] = TW'(rfpwm_pkg::acos_ticks(g, int'(AMP_MAX), int'(PERIOD)));
  end

  assign theta_o = rom[amp_i];

endmodule

// File: rtl/rfpwm_sample_regs.sv
`timescale 1ns/1ps
module rfpwm_sample_regs #(
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned TW     = 6,
  parameter int unsigned NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic [TW-1:0]     phase_i,
  input  logic [TW-1:0]     minw_i,
  input  logic              raise_i,
  input  logic [NSLICE-1:0] slice_i,
  input  logic              advance_i,
  output logic [AMP_W-1:0]  act_amp_o,
  output logic [TW-1:0]     act_phase_o,
  output logic [TW-1:0]     act_minw_o,
  output logic              act_raise_o,
  output logic [NSLICE-1:0] act_slice_o
);

  // Pending set, loaded by the strobe
  logic [AMP_W-1:0]  pnd_amp_q,   pnd_amp_d;
  logic [TW-1:0]     pnd_phase_q, pnd_phase_d;
  logic [TW-1:0]     pnd_minw_q,  pnd_minw_d;
  logic              pnd_raise_q, pnd_raise_d;
  logic [NSLICE-1:0] pnd_slice_q, pnd_slice_d;

  // Active set, loaded at the carrier boundary
  logic [AMP_W-1:0]  act_amp_q,   act_amp_d;
  logic [TW-1:0]     act_phase_q, act_phase_d;
  logic [TW-1:0]     act_minw_q,  act_minw_d;
  logic              act_raise_q, act_raise_d;
  logic [NSLICE-1:0] act_slice_q, act_slice_d;

  always_comb begin
    pnd_amp_d   = pnd_amp_q;
    pnd_phase_d = pnd_phase_q;
    pnd_minw_d  = pnd_minw_q;
    pnd_raise_d = pnd_raise_q;
    pnd_slice_d = pnd_slice_q;
    if (valid_i) begin
      pnd_amp_d   = amp_i;
      pnd_phase_d = phase_i;
      pnd_minw_d  = minw_i;
      pnd_raise_d = raise_i;
      pnd_slice_d = slice_i;
    end
  end

  always_comb begin
    act_amp_d   = act_amp_q;
    act_phase_d = act_phase_q;
    act_minw_d  = act_minw_q;
    act_raise_d = act_raise_q;
    act_slice_d = act_slice_q;
    if (advance_i) begin
      act_amp_d   = pnd_amp_q;
      act_phase_d = pnd_phase_q;
      act_minw_d  = pnd_minw_q;
      act_raise_d = pnd_raise_q;
      act_slice_d = pnd_slice_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnd_amp_q   <= '0;
      pnd_phase_q <= '0;
      pnd_minw_q  <= '0;
      pnd_raise_q <= 1'b0;
      pnd_slice_q <= '0;
      act_amp_q   <= '0;
      act_phase_q <= '0;
      act_minw_q  <= '0;
      act_raise_q <= 1'b0;
      act_slice_q <= '0;
    end else begin
      pnd_amp_q   <= pnd_amp_d;
      pnd_phase_q <= pnd_phase_d;
      pnd_minw_q  <= pnd_minw_d;
      pnd_raise_q <= pnd_raise_d;
      pnd_slice_q <= pnd_slice_d;
      act_amp_q   <= act_amp_d;
      act_phase_q <= act_phase_d;
      act_minw_q  <= act_minw_d;
      act_raise_q <= act_raise_d;
      act_slice_q <= act_slice_d;
    end
  end

  assign act_amp_o   = act_amp_q;
  assign act_phase_o = act_phase_q;
  assign act_minw_o  = act_minw_q;
  assign act_raise_o = act_raise_q;
  assign act_slice_o = act_slice_q;

endmodule

// File: rtl/rfpwm_pulse_core.sv
`timescale 1ns/1ps
module rfpwm_pulse_core #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned TW     = $clog2(PERIOD)
) (
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] phase_i,
  input  logic [TW-1:0] theta_i,
  input  logic [TW-1:0] minw_i,
  input  logic          raise_i,
  input  logic          amp_zero_i,
  output logic          pulse_o
);

  localparam int unsigned HALF = PERIOD / 2;

  logic [TW:0]   half_w;
  logic [TW:0]   minw_w;
  logic [TW:0]   w_nat;
  logic          under;
  logic [TW-1:0] theta_max;
  logic [TW-1:0] theta_eff;
  logic [TW-1:0] ph_lead;
  logic [TW-1:0] ph_lag;
  logic [TW-1:0] d_lead;
  logic [TW-1:0] d_lag;
  logic          wave_lead;
  logic          wave_lag;
  logic          kill;

  always_comb begin
    half_w = (TW+1)'(HALF);
    minw_w = {1'b0, minw_i};
    // natural width; theta never exceeds a quarter period
    w_nat  = half_w - {theta_i, 1'b0};
    under  = (minw_w > w_nat);
    // largest angle that still leaves minw ticks
    if (minw_w >= half_w) begin
      theta_max = '0;
    end else begin
      theta_max = TW'((half_w - minw_w) >> 1);
    end
    theta_eff = (under && (raise_i == rfpwm_pkg::UNDER_RAISE)) ? theta_max : theta_i;
    // two half-period square waves, modulo-N distance by truncation
    ph_lead   = phase_i + theta_eff;
    ph_lag    = phase_i - theta_eff;
    d_lead    = cnt_i - ph_lead;
    d_lag     = cnt_i - ph_lag;
    wave_lead = ~d_lead[TW-1];
    wave_lag  = ~d_lag[TW-1];
    kill      = amp_zero_i | (under & (raise_i == rfpwm_pkg::UNDER_DROP));
    pulse_o   = wave_lead & wave_lag & ~kill;
  end

endmodule

// File: rtl/rfpwm_outphase.sv
`timescale 1ns/1ps
module rfpwm_outphase #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned NSLICE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      samp_valid_i,
  input  logic [AMP_W-1:0]          samp_amp_i,
  input  logic [$clog2(PERIOD)-1:0] samp_phase_i,
  input  logic [$clog2(PERIOD)-1:0] min_width_i,
  input  logic                      raise_mode_i,
  input  logic [NSLICE-1:0]         slice_req_i,
  output logic                      pulse_o,
  output logic                      period_start_o,
  output logic [NSLICE-1:0]         slice_en_o
);

  localparam int unsigned TW = $clog2(PERIOD);

  logic [TW-1:0]     cnt;
  logic              cnt_last;
  logic [AMP_W-1:0]  act_amp;
  logic [TW-1:0]     act_phase;
  logic [TW-1:0]     act_minw;
  logic              act_raise;
  logic [NSLICE-1:0] act_slice;
  logic [TW-1:0]     theta;
  logic              core_pulse;

  rfpwm_tick_ctr #(.PERIOD(PERIOD), .TW(TW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  rfpwm_sample_regs #(.AMP_W(AMP_W), .TW(TW), .NSLICE(NSLICE)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (samp_valid_i),
    .amp_i       (samp_amp_i),
    .phase_i     (samp_phase_i),
    .minw_i      (min_width_i),
    .raise_i     (raise_mode_i),
    .slice_i     (slice_req_i),
    .advance_i   (cnt_last),
    .act_amp_o   (act_amp),
    .act_phase_o (act_phase),
    .act_minw_o  (act_minw),
    .act_raise_o (act_raise),
    .act_slice_o (act_slice)
  );

  rfpwm_acos_lut #(.AMP_W(AMP_W), .PERIOD(PERIOD), .TW(TW)) u_lut (
    .amp_i   (act_amp),
    .theta_o (theta)
  );

  rfpwm_pulse_core #(.PERIOD(PERIOD), .TW(TW)) u_core (
    .cnt_i      (cnt),
    .phase_i    (act_phase),
    .theta_i    (theta),
    .minw_i     (act_minw),
    .raise_i    (act_raise),
    .amp_zero_i (act_amp == '0),
    .pulse_o    (core_pulse)
  );

  // Output stage: one register for pulse, marker and slices keeps them aligned
  logic              pulse_q, pulse_d;
  logic              start_q, start_d;
  logic [NSLICE-1:0] slice_q, slice_d;

  always_comb begin
    pulse_d = core_pulse;
    start_d = (cnt == '0);
    slice_d = act_slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      start_q <= 1'b0;
      slice_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      start_q <= start_d;
      slice_q <= slice_d;
    end
  end

  assign pulse_o        = pulse_q;
  assign period_start_o = start_q;
  assign slice_en_o     = slice_q;

endmodule

// File: rtl/rfpwm_checker.sv
`timescale 1ns/1ps
module rfpwm_checker #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned NSLICE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_o,
  input logic              period_start_o,
  input logic [NSLICE-1:0] slice_en_o,
  input logic [AMP_W-1:0]  act_amp
);

  localparam int unsigned CW = $clog2(PERIOD) + 1;

  logic [CW-1:0] gap_q;
  logic [CW-1:0] hi_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      hi_q   <= '0;
      seen_q <= 1'b0;
    end else if (period_start_o) begin
      gap_q  <= CW'(1);
      hi_q   <= CW'(pulse_o);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
      hi_q   <= hi_q + CW'(pulse_o);
    end
  end

  // R2: markers exactly one period apart
  a_r2_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_o && seen_q) |-> (gap_q == CW'(PERIOD)));

  // R3: never more than half a period high
  a_r3_duty_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_o && seen_q) |-> (hi_q <= CW'(PERIOD / 2)));

  // R9: slice enables move only on a period start
  a_r9_slice_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start_o) |-> $stable(slice_en_o));

  // R7: zero amplitude gives a low drive
  a_r7_zero_amp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_amp == '0) |=> !pulse_o);

  // R10: quiet outputs in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!pulse_o && !period_start_o && (slice_en_o == '0));
    end
  end

endmodule

bind rfpwm_outphase rfpwm_checker #(
  .PERIOD (PERIOD),
  .AMP_W  (AMP_W),
  .NSLICE (NSLICE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pulse_o        (pulse_o),
  .period_start_o (period_start_o),
  .slice_en_o     (slice_en_o),
  .act_amp        (act_amp)
);

// File: tb/rfpwm_outphase_bench.sv
`timescale 1ns/1ps
module rfpwm_outphase_bench;

  localparam int N  = 64;
  localparam int AW = 8;
  localparam int TW = 6;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_valid_i = 1'b0;
  logic [AW-1:0] samp_amp_i = '0;
  logic [TW-1:0] samp_phase_i = '0;
  logic [TW-1:0] min_width_i = '0;
  logic          raise_mode_i = 1'b0;
  logic [NS-1:0] slice_req_i = '0;
  logic          pulse_o;
  logic          period_start_o;
  logic [NS-1:0] slice_en_o;

  always #2 clk = ~clk;

  rfpwm_outphase u_rfpwm_outphase (
    .clk            (clk),
    .rst_n          (rst_n),
    .samp_valid_i   (samp_valid_i),
    .samp_amp_i     (samp_amp_i),
    .samp_phase_i   (samp_phase_i),
    .min_width_i    (min_width_i),
    .raise_mode_i   (raise_mode_i),
    .slice_req_i    (slice_req_i),
    .pulse_o        (pulse_o),
    .period_start_o (period_start_o),
    .slice_en_o     (slice_en_o)
  );

  typedef struct {
    int tag;
    int amp;
    int ph;
    int minw;
    int raise;
    int slc;
    int kind;   // 0 new sample, 1 held over, 2 reset state
  } item_t;

  item_t    q[$];
  item_t    prev_cfg;
  int       n_tests = 0;
  int       n_fail = 0;
  int       cur_per = 0;
  int       last_tag = -1;
  bit       started = 1'b0;
  bit       done = 1'b0;
  logic [N-1:0] pat;
  int       idx = 0;
  int       slc_start = 0;
  bit       slc_moved = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void exp_width(input item_t it, output int lo, output int hi, output string req);
    real th;
    int  wf;
    if (it.amp == 0) begin
      lo = 0; hi = 0; req = (it.kind == 2) ? "R10" : "R7";
      return;
    end
    th = $acos(real'(it.amp) / 255.0);
    wf = $rtoi(real'(N) * (0.5 - th / 3.14159265358979) + 0.5);
    if (wf < it.minw - 1) begin
      if (it.raise != 0) begin
        lo = (it.minw < N/2) ? it.minw : N/2;
        hi = (it.minw + 1 < N/2) ? it.minw + 1 : N/2;
        req = "R5";
      end else begin
        lo = 0; hi = 0; req = "R6";
      end
    end else begin
      lo = wf - 1; hi = wf + 1; req = "R3";
    end
    if (it.kind == 1) req = {req, "/R8"};
  endfunction

  task automatic judge(input item_t it);
    int    w;
    int    runs;
    int    st;
    int    lo;
    int    hi;
    int    est;
    string req;
    w = $countones(pat);
    runs = 0;
    st = -1;
    for (int i = 0; i < N; i++) begin
      if (pat[i] && !pat[(i + N - 1) % N]) begin
        runs++;
        st = i;
      end
    end
    exp_width(it, lo, hi, req);
    chk(idx == N, "R2", "period length", idx, N);
    n_tests++;
    if (w < lo || w > hi) begin
      n_fail++;
      $display("FAIL %s width: actual %0d expected %0d..%0d (period %0d)", req, w, lo, hi, it.tag);
    end
    chk(w <= N/2, "R3", "width ceiling", w, N/2);
    if (it.amp == 255) chk(w == N/2, "R3", "full-scale width", w, N/2);
    if (lo > 0 && w > 0) begin
      chk(runs == 1, "R1", "high runs in period", runs, 1);
      est = (((it.ph + N/4 - w/2) % N) + N) % N;
      chk(st == est, (req == "R5") ? "R5" : "R4", "pulse start tick", st, est);
    end
    chk(slc_start == it.slc, "R9", "slice enables", slc_start, it.slc);
    chk(!slc_moved, "R9", "slice change inside period", int'(slc_moved), 0);
  endtask

  task automatic finalize(int k);
    item_t it;
    while (q.size() > 0 && q[0].tag < k) begin
      it = q.pop_front();
      chk(1'b0, "R2", "period never observed", k, it.tag);
    end
    while (q.size() > 0 && q[0].tag == k) begin
      it = q.pop_front();
      judge(it);
    end
  endtask

  // Monitor: rebuilds each period from the start marker
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (period_start_o) begin
        if (started) begin
          finalize(cur_per);
          cur_per++;
        end else begin
          started = 1'b1;
        end
        idx = 0;
        slc_start = int'(slice_en_o);
        slc_moved = 1'b0;
      end
      if (started) begin
        if (idx < N) pat[idx] = pulse_o;
        idx++;
        if (!period_start_o && int'(slice_en_o) != slc_start) slc_moved = 1'b1;
      end
    end
  end

  task automatic wait_start();
    do @(negedge clk); while (!period_start_o);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) wait_start();
  endtask

  // Driver: strobe in the third cycle of a period, queue old and new expectations
  task automatic apply(int amp, int ph, int minw, int raise, int slc);
    item_t it;
    wait_start();
    @(negedge clk);
    if (cur_per != last_tag) begin
      it = prev_cfg;
      it.tag = cur_per;
      if (it.kind != 2) it.kind = 1;
      q.push_back(it);
    end
    samp_amp_i   = AW'(amp);
    samp_phase_i = TW'(ph);
    min_width_i  = TW'(minw);
    raise_mode_i = raise[0];
    slice_req_i  = NS'(slc);
    samp_valid_i = 1'b1;
    @(negedge clk);
    samp_valid_i = 1'b0;
    samp_amp_i   = 8'hA5;
    samp_phase_i = 6'd31;
    it = '{tag: cur_per + 1, amp: amp, ph: ph, minw: minw, raise: raise, slc: slc, kind: 0};
    q.push_back(it);
    prev_cfg = it;
    last_tag = cur_per + 1;
  endtask

  initial begin
    prev_cfg = '{tag: 0, amp: 0, ph: 0, minw: 0, raise: 0, slc: 0, kind: 2};
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R10", "pulse in reset", int'(pulse_o), 0);
    chk(period_start_o == 1'b0, "R10", "marker in reset", int'(period_start_o), 0);
    chk(slice_en_o == '0, "R10", "slices in reset", int'(slice_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_start_o == 1'b1, "R10", "first period after release", int'(period_start_o), 1);

    apply(255,  0, 12, 1, 4'b0001);   // R3 full scale, R4 phase 0
    idle(1);
    apply(180, 17, 12, 1, 4'b0011);   // R3 mid amplitude, R8 held period
    apply(128, 50,  8, 1, 4'b1010);   // R4 wrap across boundary
    idle(1);
    apply(  0,  5, 12, 1, 4'b1111);   // R7 zero amplitude
    apply( 40, 63, 12, 1, 4'b0101);   // R5 widened
    apply( 40, 63, 12, 0, 4'b0110);   // R6 dropped
    idle(1);
    apply(255,  9, 40, 1, 4'b1000);   // R5 minimum above half period
    apply(100,  5, 12, 0, 4'b0000);   // R6 dropped
    apply(220, 33, 12, 0, 4'b1111);   // R3 above minimum, drop mode inert
    idle(2);
    @(negedge clk);
    chk(q.size() == 0, "R2", "unchecked periods left", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule